// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block is an 8-bit general-purpose I/O port. Each pin has a direction bit, a bit in the output data latch and a pull-up request. The pads are modelled at the edge as an output enable, an output value and a pull-up request per pin. The raw pad input enters through a two-flop synchronizer. A small register interface on the bus side does four things:
- It reads the synchronized pins back.
- It writes the output latch, either as a full byte or as a single bit done read-modify-write.
- It reads and writes the direction register.
- It controls one global pull-up disable bit and an interrupt-control register.

The upper four pins can raise a change interrupt. Only the pins configured as inputs take part. Each of them is compared with a snapshot that is recaptured on every access to the port data register, not with its value on the previous clock. The mismatches set a sticky flag. The flag drives a wake request directly. The interrupt request is the flag gated by an enable bit. A typical use is a keypad scanned by software: the port is read to arm the detector, and a key press then wakes the system.

Top module: `gpio_cio_port`

## Requirements
- R1: Direction bit 1 makes a pin an input (pin_oe low). Direction bit 0 sets pin_oe high and drives the latch bit on pin_out. The direction register sits at address 1, resets to all ones and is written by a bus write; the new value is visible at the pins one clock later.
- R2: A read at address 0 returns the synchronized pin values and never the output latch. A pin_in change shows in the read data after two clock edges.
- R3: A byte write at address 0 (bus_bit low) loads bus_wdata into the output latch, which appears on pin_out one clock later. The latch resets to 0.
- R4: A bit write (bus_wr with bus_bit high) takes the current read value of the addressed register. It replaces bit bus_bsel with bus_bval and stores the whole result. At address 0 this means the latch receives the synchronized pin values with one bit changed.
- R5: Address 2 bit 0 is an active-low global pull-up enable and resets to 1. Each pin_pu[i] is high only when that bit is 0 and direction bit i is 1.
- R6: A mismatch exists when a pin in bits 7:4 is configured as an input and its synchronized value differs from the snapshot. A mismatch sets the sticky flag on the next clock, so the flag appears three clocks after the pin_in change. Output pins and bits 3:0 never set it.
- R7: Any read or write at address 0 recaptures the snapshot from the synchronized bits 7:4. No mismatch is counted in that access cycle, so a change that reaches the synchronizer output in that same cycle sets no flag.
- R8: The flag is cleared by writing address 3 with bit 1 equal to 0, and writing 1 there leaves it unchanged. While a mismatch persists, the flag stays set despite the clear.
- R9: Address 3 bit 0 is the interrupt enable and resets to 0. irq_o equals flag AND enable. wake_o equals the flag alone. The flag resets to 0.
- R10: Read data is combinational from bus_addr. Address 1 returns the direction register, address 2 returns the pull-up disable in bit 0, and address 3 returns the enable in bit 0 and the flag in bit 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Read strobe for the addressed register |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_bit | input | 1 | Selects a single-bit read-modify-write instead of a byte write |
| bus_bsel | input | 3 | Bit index for a bit write |
| bus_bval | input | 1 | Bit value for a bit write |
| bus_addr | input | 2 | Register address: 0 port, 1 direction, 2 pull-up, 3 interrupt control |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| pin_in | input | 8 | Raw pad input values |
| pin_oe | output | 8 | Per-pin output enable (high drives) |
| pin_out | output | 8 | Per-pin output value (output latch) |
| pin_pu | output | 8 | Per-pin weak pull-up request |
| irq_o | output | 1 | Change interrupt request, gated by enable |
| wake_o | output | 1 | Wake request from the change flag |

## Verification
Register writes reach pin_oe, pin_out, pin_pu and the read data one clock after the strobe. A pin_in change reaches the port read data after two clocks, and the flag, irq_o and wake_o after three. The bench drives inputs on the falling edge and advances a cycle-by-cycle reference model on each rising edge. It compares every output on the next falling edge, so each result is checked in the cycle it falls due. Directed cases place a pin change in the read cycle, a clear during a persisting mismatch, and a change on an output-configured pin. These cases land at exactly those latencies.

// File: rtl/gpio_cio_pkg.sv
package gpio_cio_pkg;

  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_ICTL = 2'd3
  } reg_addr_e;

  localparam int PULL_OFF_BIT  = 0;
  localparam int ICTL_EN_BIT   = 0;
  localparam int ICTL_FLAG_BIT = 1;

endpackage

// File: rtl/gpio_cio_sync.sv
module gpio_cio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_cio_regs.sv
module gpio_cio_regs
  import gpio_cio_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int BW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_bit,
  input  logic [BW-1:0]    bus_bsel,
  input  logic             bus_bval,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pins_s,
  input  logic             flag,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q,
  output logic             pull_off_q,
  output logic             ien_q,
  output logic             port_access,
  output logic             flag_clr
);

  reg_addr_e        addr;
  logic [WIDTH-1:0] rd_val;
  logic [WIDTH-1:0] wval;
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] lat_d;
  logic             pull_off_d;
  logic             ien_d;

  assign addr = reg_addr_e'(bus_addr);

  always_comb begin
    rd_val = '0;
    case (addr)
      REG_PORT: rd_val = pins_s;
      REG_DIR:  rd_val = dir_q;
      REG_PULL: rd_val[PULL_OFF_BIT] = pull_off_q;
      REG_ICTL: begin
        rd_val[ICTL_EN_BIT]   = ien_q;
        rd_val[ICTL_FLAG_BIT] = flag;
      end
      default:  rd_val = '0;
    endcase
  end

  assign bus_rdata = rd_val;

  always_comb begin
    wval = bus_wdata;
    if (bus_bit) begin
      wval           = rd_val;
      wval[bus_bsel] = bus_bval;
    end
  end

  assign port_access = (bus_rd || bus_wr) && (addr == REG_PORT);
  assign flag_clr    = bus_wr && (addr == REG_ICTL) && !wval[ICTL_FLAG_BIT];

  always_comb begin
    dir_d      = dir_q;
    lat_d      = lat_q;
    pull_off_d = pull_off_q;
    ien_d      = ien_q;
    if (bus_wr) begin
      case (addr)
        REG_PORT: lat_d      = wval;
        REG_DIR:  dir_d      = wval;
        REG_PULL: pull_off_d = wval[PULL_OFF_BIT];
        REG_ICTL: ien_d      = wval[ICTL_EN_BIT];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q      <= '1;
      lat_q      <= '0;
      pull_off_q <= 1'b1;
      ien_q      <= 1'b0;
    end else begin
      dir_q      <= dir_d;
      lat_q      <= lat_d;
      pull_off_q <= pull_off_d;
      ien_q      <= ien_d;
    end
  end

  // R3
  port_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_bit && bus_addr == REG_PORT) |=> lat_q == $past(bus_wdata));

  // R1
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_bit && bus_addr == REG_DIR) |=> dir_q == $past(bus_wdata));

  // R4
  bit_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_bit && bus_addr == REG_PORT) |=> lat_q[$past(bus_bsel)] == $past(bus_bval));

endmodule

// File: rtl/gpio_cio_chg.sv
module gpio_cio_chg #(
  parameter int WIDTH  = 8,
  parameter int CHG_LO = 4,
  localparam int NCHG  = WIDTH - CHG_LO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_s,
  input  logic [WIDTH-1:0] dir,
  input  logic             port_access,
  input  logic             flag_clr,
  output logic             flag
);

  logic [NCHG-1:0] snap_q;
  logic [NCHG-1:0] snap_d;
  logic [NCHG-1:0] diff;
  logic            mism;
  logic            flag_q;
  logic            flag_d;

  assign diff = (pins_s[WIDTH-1:CHG_LO] ^ snap_q) & dir[WIDTH-1:CHG_LO];
  assign mism = (|diff) && !port_access;

  always_comb begin
    snap_d = snap_q;
    if (port_access) snap_d = pins_s[WIDTH-1:CHG_LO];
    flag_d = mism | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      snap_q <= snap_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mism |=> flag_q);

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(flag_clr));

  // R7
  access_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_access && !flag_q) |=> !flag_q);

endmodule

// File: rtl/gpio_cio_port.sv
module gpio_cio_port
  import gpio_cio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int CHG_LO      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int BW         = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_bit,
  input  logic [BW-1:0]    bus_bsel,
  input  logic             bus_bval,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pu,
  output logic             irq_o,
  output logic             wake_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [WIDTH-1:0] pins_s;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lat_q;
  logic             pull_off_q;
  logic             ien_q;
  logic             port_access;
  logic             flag_clr;
  logic             flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  gpio_cio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d     (pin_in),
    .q     (pins_s)
  );

  gpio_cio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_ni),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_bit     (bus_bit),
    .bus_bsel    (bus_bsel),
    .bus_bval    (bus_bval),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pins_s      (pins_s),
    .flag        (flag),
    .dir_q       (dir_q),
    .lat_q       (lat_q),
    .pull_off_q  (pull_off_q),
    .ien_q       (ien_q),
    .port_access (port_access),
    .flag_clr    (flag_clr)
  );

  gpio_cio_chg #(.WIDTH(WIDTH), .CHG_LO(CHG_LO)) u_chg (
    .clk         (clk),
    .rst_n       (rst_ni),
    .pins_s      (pins_s),
    .dir         (dir_q),
    .port_access (port_access),
    .flag_clr    (flag_clr),
    .flag        (flag)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pin_oe[i] = ~dir_q[i];
    assign pin_pu[i] = dir_q[i] & ~pull_off_q;
  end

  assign pin_out = lat_q;
  assign irq_o   = flag & ien_q;
  assign wake_o  = flag;

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (wake_o && bus_rdata == bus_rdata));

endmodule

// File: tb/tb_gpio_cio_port.sv
`timescale 1ns/1ps
module tb_gpio_cio_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_rd, bus_wr, bus_bit, bus_bval;
  logic [2:0] bus_bsel;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pin_in, pin_oe, pin_out, pin_pu;
  logic       irq_o, wake_o;

  int nchk  = 0;
  int nfail = 0;

  logic [7:0] m_s1, m_s2, m_dir, m_lat;
  logic [3:0] m_snap;
  logic       m_poff, m_ien, m_flag;
  logic [7:0] cur_pins;
  logic [1:0] cur_addr;

  always #4 clk = ~clk;

  gpio_cio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_bit(bus_bit),
    .bus_bsel(bus_bsel), .bus_bval(bus_bval), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_pu(pin_pu), .irq_o(irq_o), .wake_o(wake_o)
  );

  function automatic logic [7:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_s2;
      2'd1:    return m_dir;
      2'd2:    return {7'b0, m_poff};
      default: return {6'b0, m_flag, m_ien};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic bt, input logic [2:0] bs,
                      input logic bv, input logic [1:0] a, input logic [7:0] wd,
                      input logic [7:0] pins);
    logic [7:0] wv;
    logic       acc, mism, clr;
    bus_rd = rd; bus_wr = wr; bus_bit = bt; bus_bsel = bs; bus_bval = bv;
    bus_addr = a; bus_wdata = wd; pin_in = pins;
    cur_addr = a; cur_pins = pins;
    @(posedge clk);
    wv = wd;
    if (bt) begin wv = m_rd(a); wv[bs] = bv; end
    acc  = (rd || wr) && a == 2'd0;
    mism = !acc && (|((m_s2[7:4] ^ m_snap) & m_dir[7:4]));
    clr  = wr && a == 2'd3 && !wv[1];
    m_flag = mism | (m_flag & ~clr);
    if (acc) m_snap = m_s2[7:4];
    if (wr) begin
      case (a)
        2'd0: m_lat  = wv;
        2'd1: m_dir  = wv;
        2'd2: m_poff = wv[0];
        default: m_ien = wv[0];
      endcase
    end
    m_s2 = m_s1;
    m_s1 = pins;
    @(negedge clk);
    chk("R1 pin_oe", pin_oe, ~m_dir);
    chk("R3 pin_out", pin_out, m_lat);
    chk("R5 pin_pu", pin_pu, m_dir & ~{8{m_poff}});
    chk("R6 wake_o", {7'b0, wake_o}, {7'b0, m_flag});
    chk("R9 irq_o", {7'b0, irq_o}, {7'b0, m_flag & m_ien});
    chk(a == 2'd0 ? "R2 rdata" : "R10 rdata", bus_rdata, m_rd(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, cur_addr, 0, cur_pins);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(0, 1, 0, 0, 0, a, d, cur_pins);
  endtask

  task automatic rd(input logic [1:0] a);
    step(1, 0, 0, 0, 0, a, 0, cur_pins);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_bit = 0; bus_bsel = 0; bus_bval = 0;
    bus_addr = 2'd1; bus_wdata = 0; pin_in = 0;
    cur_addr = 2'd1; cur_pins = 0;
    m_s1 = 0; m_s2 = 0; m_dir = 8'hFF; m_lat = 0; m_snap = 0;
    m_poff = 1; m_ien = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state: R1 R5 R9 R10
    chk("R1 reset oe", pin_oe, 8'h00);
    chk("R5 reset pu", pin_pu, 8'h00);
    chk("R9 reset wake", {7'b0, wake_o}, 8'h00);
    chk("R10 reset dir", bus_rdata, 8'hFF);

    // Pull-ups and direction: R5 R1
    wr(2'd2, 8'h00);
    chk("R5 pu on", pin_pu, 8'hFF);
    wr(2'd1, 8'h0F);
    chk("R1 oe", pin_oe, 8'hF0);
    chk("R5 pu inputs only", pin_pu, 8'h0F);

    // Byte write: R3
    wr(2'd0, 8'hA5);
    chk("R3 latch", pin_out, 8'hA5);

    // Pin read and bit RMW: R2 R4; change on output pins ignored: R6
    cur_pins = 8'h3C;
    idle(3);
    rd(2'd0);
    chk("R2 pins not latch", bus_rdata, 8'h3C);
    step(0, 1, 1, 3'd7, 1, 2'd0, 8'h00, cur_pins);
    chk("R4 rmw", pin_out, 8'hBC);
    chk("R6 masked outputs", {7'b0, wake_o}, 8'h00);

    // Change detection, sticky clear: R6 R8 R9
    wr(2'd1, 8'hFF);
    rd(2'd0);
    cur_pins = 8'h1C;
    idle(4);
    chk("R6 flag set", {7'b0, wake_o}, 8'h01);
    chk("R9 irq gated", {7'b0, irq_o}, 8'h00);
    wr(2'd3, 8'h01);
    chk("R8 persists", {7'b0, wake_o}, 8'h01);
    chk("R9 irq enabled", {7'b0, irq_o}, 8'h01);
    rd(2'd0);
    wr(2'd3, 8'h01);
    chk("R8 cleared", {7'b0, wake_o}, 8'h00);
    rd(2'd3);
    chk("R10 ictl", bus_rdata, 8'h01);

    // Lower pins never flag: R6
    cur_pins = 8'h13;
    idle(4);
    chk("R6 low pins", {7'b0, wake_o}, 8'h00);

    // Same-cycle change and read: R7
    step(0, 0, 0, 0, 0, 2'd3, 0, 8'h33);
    idle(1);
    rd(2'd0);
    idle(3);
    chk("R7 same cycle", {7'b0, wake_o}, 8'h00);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [7:0] p;
      p = cur_pins;
      if (($urandom % 6) == 0) p[$urandom % 8] = ~p[$urandom % 8];
      op = $urandom % 16;
      case (op)
        6:  step(1, 0, 0, 0, 0, 2'd0, 0, p);
        7:  step(0, 1, 0, 0, 0, 2'd0, 8'($urandom), p);
        8:  step(0, 1, 1, 3'($urandom), 1'($urandom), 2'($urandom), 0, p);
        9:  step(0, 1, 0, 0, 0, 2'd1, 8'($urandom), p);
        10: step(0, 1, 0, 0, 0, 2'd2, 8'($urandom), p);
        11: step(0, 1, 0, 0, 0, 2'd3, 8'($urandom), p);
        12: step(1, 0, 0, 0, 0, 2'($urandom), 0, p);
        default: step(0, 0, 0, 0, 0, 2'($urandom), 0, p);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule